// File: doc/BRIEF.md
# Touch Key Baseline Drift Tracker

This block keeps a reference level (the baseline) for each of several capacitive touch keys, and handles the case where a key's measured signal sits above that reference. A small positive error is worked out slowly: the reference steps up by one count each time a programmable drift period ends. A larger error is one that exceeds a programmable positive threshold. If it lasts for a programmable confirmation delay, the block recalibrates every key at once. Every reference is reloaded from its key's present signal, and a single-cycle pulse reports the event.

The effective threshold drops by a coded fraction while a key is already flagged as above it. A signal near the boundary therefore cannot chatter between drift handling and recalibration. A hold input freezes drift timing without discarding progress. Timers advance only on a slow time-base tick, nominally every 160 ms. A configuration strobe loads the threshold, the hysteresis code, the drift period and the confirmation delay, and each has a default after reset.

Top module: `touch_baseline_tracker`

## Requirements
- R1: While `rst` is high, each key's reference follows its signal, `over` and `recal_all` are 0, and the configuration returns to threshold 4, hysteresis code 2, drift period 6 and confirmation delay 6.
- R2: While a key's signal is above its reference and the drift period P is non-zero, the reference rises by exactly 1. This happens on the edge of the P-th tick counted from when the error appeared or from the previous step.
- R3: A reference never moves above the signal it drifts toward. A drift period of 0 stops all drift.
- R4: While `hold` is high, ticks do not advance drift timing. On release, counting resumes from the value it held, not from zero.
- R5: With `over` low for a key, the key enters positive detection when signal minus reference is strictly greater than the threshold. `over` shows this one clock edge after the inputs are applied.
- R6: While `over` is high, the comparison uses threshold − floor(threshold × code / 8), where code is the 2-bit hysteresis value: 0 gives no reduction, 1 gives 12.5 %, 2 gives 25 % and 3 gives 37.5 %.
- R7: A key that stays above its effective threshold causes a recalibration on the D-th tick it sees there, where D is the confirmation delay and a delay of 0 acts as 1. No recalibration happens without a tick.
- R8: If the key drops to or below its effective threshold before the confirmation completes, its tick count is cleared. Later confirmation then needs the full D ticks again.
- R9: A recalibration loads every key's reference with that key's signal at the triggering edge and clears all timers. `recal_all` is high for exactly the following cycle.
- R10: When a recalibration and a drift step fall on the same edge, the recalibration wins. The drifting key's reference takes its signal value, not the old reference plus one.
- R11: A configuration write with `cfg_we` high is applied from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base strobe, nominally every 160 ms |
| hold | input | 1 | Freezes drift timing while high |
| cfg_we | input | 1 | Loads the four configuration fields |
| cfg_thr | input | 8 | Positive threshold in counts |
| cfg_hyst | input | 2 | Hysteresis code |
| cfg_drift | input | 7 | Drift period in ticks, 0 disables drift |
| cfg_delay | input | 8 | Confirmation delay in ticks |
| sig_in | input | NKEYS*SIG_W | Measured signals, key k at bits k*SIG_W upward |
| ref_out | output | NKEYS*SIG_W | References, same packing as `sig_in` |
| over | output | NKEYS | Per-key positive-detection flag |
| recal_all | output | 1 | One-cycle pulse after a global recalibration |

## Verification
A drift step on one key and a confirmed recalibration started by another key can land on the same tick. To provoke this, the bench sets a drift period of 2 and a confirmation delay of 2. It then applies, together, a small error on one key and a large error on a second key, so that both timers reach their ends on the second tick. The check passes if the drifting key's reference equals its signal, not its old reference plus one, and if `recal_all` pulses once. Separate runs of each function on its own set the baseline against which this collision is judged.

// File: rtl/bt_pkg.sv
`timescale 1ns/1ps
package bt_pkg;
  localparam int THR_W   = 8;
  localparam int HYST_W  = 2;
  localparam int DRIFT_W = 7;
  localparam int DLY_W   = 8;

  localparam logic [THR_W-1:0]   DEF_THR   = 8'd4;
  localparam logic [HYST_W-1:0]  DEF_HYST  = 2'd2;
  localparam logic [DRIFT_W-1:0] DEF_DRIFT = 7'd6;
  localparam logic [DLY_W-1:0]   DEF_DELAY = 8'd6;

  typedef struct packed {
    logic [THR_W-1:0]   thr;
    logic [HYST_W-1:0]  hyst;
    logic [DRIFT_W-1:0] drift;
    logic [DLY_W-1:0]   delay;
  } cfg_t;

  // amount removed from the threshold: floor(thr * code / 8)
  function automatic logic [THR_W-1:0] hyst_cut(input logic [THR_W-1:0] thr,
                                                input logic [HYST_W-1:0] code);
    logic [THR_W+HYST_W-1:0] prod;
    prod = {{HYST_W{1'b0}}, thr} * {{THR_W{1'b0}}, code};
    return THR_W'(prod >> 3);
  endfunction
endpackage

// File: rtl/bt_cfg.sv
`timescale 1ns/1ps
module bt_cfg
  import bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.thr   <= DEF_THR;
      cfg.hyst  <= DEF_HYST;
      cfg.drift <= DEF_DRIFT;
      cfg.delay <= DEF_DELAY;
    end else if (we) begin
      cfg <= wdata;
    end
  end
endmodule

// File: rtl/bt_thresh.sv
`timescale 1ns/1ps
module bt_thresh
  import bt_pkg::*;
(
  input  logic [THR_W-1:0]  thr,
  input  logic [HYST_W-1:0] code,
  input  logic              engaged,
  output logic [THR_W-1:0]  thr_eff
);
  logic [THR_W-1:0] cut;
  always_comb begin
    cut     = hyst_cut(thr, code);
    thr_eff = engaged ? (thr - cut) : thr;
  end
endmodule

// File: rtl/bt_lane.sv
`timescale 1ns/1ps
module bt_lane
  import bt_pkg::*;
#(
  parameter int SIG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             hold,
  input  logic             recal,
  input  cfg_t             cfg,
  input  logic [SIG_W-1:0] sig,
  output logic [SIG_W-1:0] base_q,
  output logic             det_q,
  output logic             confirm
);
  localparam int CMP_W = (SIG_W > THR_W) ? SIG_W : THR_W;
  localparam logic [DRIFT_W:0] ONE_D = 1;
  localparam logic [DLY_W:0]   ONE_L = 1;

  logic [THR_W-1:0]   thr_eff;
  logic [SIG_W-1:0]   diff;
  logic               pos, above, step;
  logic [DRIFT_W-1:0] dcnt;
  logic [DLY_W-1:0]   lcnt;

  bt_thresh u_thr (
    .thr    (cfg.thr),
    .code   (cfg.hyst),
    .engaged(det_q),
    .thr_eff(thr_eff)
  );

  always_comb begin
    pos     = sig > base_q;
    diff    = sig - base_q;
    above   = pos && (CMP_W'(diff) > CMP_W'(thr_eff));
    step    = tick && !hold && pos && (cfg.drift != '0) &&
              (({1'b0, dcnt} + ONE_D) >= {1'b0, cfg.drift});
    confirm = tick && above &&
              (({1'b0, lcnt} + ONE_L) >= {1'b0, cfg.delay});
  end

  always_ff @(posedge clk) begin
    if (rst || recal) begin
      base_q <= sig;
      det_q  <= 1'b0;
      dcnt   <= '0;
      lcnt   <= '0;
    end else begin
      det_q <= above;
      // confirmation tick count
      if (!above)    lcnt <= '0;
      else if (tick) lcnt <= lcnt + DLY_W'(1);
      // drift period timer
      if (!pos || cfg.drift == '0) dcnt <= '0;
      else if (step)               dcnt <= '0;
      else if (tick && !hold)      dcnt <= dcnt + DRIFT_W'(1);
      if (step) base_q <= base_q + SIG_W'(1);
    end
  end
endmodule

// File: rtl/touch_baseline_tracker.sv
`timescale 1ns/1ps
module touch_baseline_tracker
  import bt_pkg::*;
#(
  parameter int NKEYS = 4,
  parameter int SIG_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   hold,
  input  logic                   cfg_we,
  input  logic [7:0]             cfg_thr,
  input  logic [1:0]             cfg_hyst,
  input  logic [6:0]             cfg_drift,
  input  logic [7:0]             cfg_delay,
  input  logic [NKEYS*SIG_W-1:0] sig_in,
  output logic [NKEYS*SIG_W-1:0] ref_out,
  output logic [NKEYS-1:0]       over,
  output logic                   recal_all
);
  cfg_t             cfg_w, cfg;
  logic [NKEYS-1:0] confirm;
  logic             recal_now;

  always_comb begin
    cfg_w.thr   = cfg_thr;
    cfg_w.hyst  = cfg_hyst;
    cfg_w.drift = cfg_drift;
    cfg_w.delay = cfg_delay;
  end

  bt_cfg u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wdata(cfg_w),
    .cfg  (cfg)
  );

  assign recal_now = |confirm;

  for (genvar k = 0; k < NKEYS; k++) begin : g_lane
    bt_lane #(.SIG_W(SIG_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .hold   (hold),
      .recal  (recal_now),
      .cfg    (cfg),
      .sig    (sig_in[k*SIG_W +: SIG_W]),
      .base_q (ref_out[k*SIG_W +: SIG_W]),
      .det_q  (over[k]),
      .confirm(confirm[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) recal_all <= 1'b0;
    else     recal_all <= recal_now;
  end
endmodule

// File: rtl/bt_checker.sv
`timescale 1ns/1ps
module bt_checker #(
  parameter int NKEYS = 4,
  parameter int SIG_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   hold,
  input logic [NKEYS*SIG_W-1:0] sig_in,
  input logic [NKEYS*SIG_W-1:0] ref_out,
  input logic [NKEYS-1:0]       over,
  input logic                   recal_all
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: reset leaves no pulse and no detection
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!recal_all && over == '0));

  for (genvar k = 0; k < NKEYS; k++) begin : g_k
    // R2 / R3: reference holds or steps by one, never past the signal
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
      (past_ok && !recal_all) |->
        ((ref_out[k*SIG_W +: SIG_W] == $past(ref_out[k*SIG_W +: SIG_W])) ||
         ((ref_out[k*SIG_W +: SIG_W] == $past(ref_out[k*SIG_W +: SIG_W]) + SIG_W'(1)) &&
          (ref_out[k*SIG_W +: SIG_W] <= $past(sig_in[k*SIG_W +: SIG_W])))));

    // R4: no drift movement on an edge where hold was high
    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(hold) && !recal_all) |->
        (ref_out[k*SIG_W +: SIG_W] == $past(ref_out[k*SIG_W +: SIG_W])));

    // R5: detection only follows a positive error
    a_r5_over_needs_error: assert property (@(posedge clk) disable iff (rst)
      (past_ok && over[k]) |->
        ($past(sig_in[k*SIG_W +: SIG_W]) > $past(ref_out[k*SIG_W +: SIG_W])));

    // R9: a pulse means every reference took its signal
    a_r9_reload: assert property (@(posedge clk) disable iff (rst)
      (past_ok && recal_all) |->
        (ref_out[k*SIG_W +: SIG_W] == $past(sig_in[k*SIG_W +: SIG_W])));
  end
endmodule

bind touch_baseline_tracker bt_checker #(.NKEYS(NKEYS), .SIG_W(SIG_W)) u_bt_checker (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .sig_in   (sig_in),
  .ref_out  (ref_out),
  .over     (over),
  .recal_all(recal_all)
);

// File: tb/touch_baseline_tracker_bench.sv
`timescale 1ns/1ps
module touch_baseline_tracker_bench;
  localparam int NK    = 4;
  localparam int SW    = 12;
  localparam real CLK_P = 8.0;

  logic clk = 1'b0;
  logic rst, tick, hold, cfg_we;
  logic [7:0] cfg_thr;
  logic [1:0] cfg_hyst;
  logic [6:0] cfg_drift;
  logic [7:0] cfg_delay;
  logic [SW-1:0] sig [NK];
  logic [NK*SW-1:0] sig_in, ref_out;
  logic [NK-1:0] over;
  logic recal_all;

  always #(CLK_P/2) clk = ~clk;

  always_comb
    for (int k = 0; k < NK; k++) sig_in[k*SW +: SW] = sig[k];

  touch_baseline_tracker #(.NKEYS(NK), .SIG_W(SW)) u_touch_baseline_tracker (
    .clk(clk), .rst(rst), .tick(tick), .hold(hold), .cfg_we(cfg_we),
    .cfg_thr(cfg_thr), .cfg_hyst(cfg_hyst), .cfg_drift(cfg_drift),
    .cfg_delay(cfg_delay), .sig_in(sig_in), .ref_out(ref_out),
    .over(over), .recal_all(recal_all)
  );

  // scoreboard
  typedef struct {
    int    kind;   // 0 reference, 1 over flag, 2 recal pulse
    int    lane;
    int    val;
    string tag;
  } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic expect_item(input int kind, input int lane, input int val, input string tag);
    item_t it;
    it.kind = kind; it.lane = lane; it.val = val; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0:       act = int'(ref_out[it.lane*SW +: SW]);
        1:       act = int'(over[it.lane]);
        default: act = int'(recal_all);
      endcase
      checks++;
      if (act != it.val) begin
        errors++;
        $display("FAIL %s kind=%0d lane=%0d actual=%0d expected=%0d",
                 it.tag, it.kind, it.lane, act, it.val);
      end
    end
  end

  task automatic clk_n(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask
  task automatic tick_once();
    tick = 1'b1; clk_n(1); tick = 1'b0;
  endtask
  task automatic tick_n(input int n);
    repeat (n) begin tick_once(); clk_n(1); end
  endtask
  task automatic wr_cfg(input int t, input int h, input int d, input int l);
    cfg_thr = 8'(t); cfg_hyst = 2'(h); cfg_drift = 7'(d); cfg_delay = 8'(l);
    cfg_we = 1'b1; clk_n(1); cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; hold = 1'b0; cfg_we = 1'b0;
    cfg_thr = '0; cfg_hyst = '0; cfg_drift = '0; cfg_delay = '0;
    sig[0] = 100; sig[1] = 200; sig[2] = 300; sig[3] = 400;
    clk_n(3);
    rst = 1'b0;
    clk_n(1);
    expect_item(0, 0, 100, "R1 ref0 after reset");
    expect_item(0, 3, 400, "R1 ref3 after reset");
    expect_item(2, 0, 0,   "R1 no pulse after reset");
    expect_item(1, 0, 0,   "R1 over0 after reset");

    // drift with default period 6
    sig[0] = 102;
    tick_n(5);
    expect_item(0, 0, 100, "R2 no step before 6th tick");
    tick_n(1);
    expect_item(0, 0, 101, "R2 R1 step at 6th tick default");
    tick_n(6);
    expect_item(0, 0, 102, "R2 second step");
    tick_n(6);
    expect_item(0, 0, 102, "R3 stops at signal");

    // hold pauses drift timing, period 3
    wr_cfg(4, 2, 3, 6);
    sig[0] = 104;
    tick_n(2);
    hold = 1'b1;
    tick_n(5);
    expect_item(0, 0, 102, "R4 frozen during hold");
    hold = 1'b0;
    tick_n(1);
    expect_item(0, 0, 103, "R4 resumes from held count");
    tick_n(3);
    expect_item(0, 0, 104, "R11 new period 3 applied");

    // period 0 disables drift
    wr_cfg(4, 2, 0, 6);
    sig[0] = 106;
    tick_n(10);
    expect_item(0, 0, 104, "R3 period 0 no drift");

    // threshold and hysteresis on key 1 (ref 200), no ticks
    sig[1] = 204; clk_n(2);
    expect_item(1, 1, 0, "R5 diff equal to threshold");
    sig[1] = 205; clk_n(1);
    expect_item(1, 1, 1, "R5 diff above threshold");
    sig[1] = 204; clk_n(1);
    expect_item(1, 1, 1, "R6 code2 reduced threshold 3");
    sig[1] = 203; clk_n(1);
    expect_item(1, 1, 0, "R6 code2 leaves at 3");
    sig[1] = 204; clk_n(1);
    expect_item(1, 1, 0, "R5 full threshold again");

    wr_cfg(8, 3, 0, 6);
    sig[1] = 209; clk_n(1);
    expect_item(1, 1, 1, "R6 code3 enter");
    sig[1] = 206; clk_n(1);
    expect_item(1, 1, 1, "R6 code3 threshold 5 held");
    sig[1] = 205; clk_n(1);
    expect_item(1, 1, 0, "R6 code3 leave");

    wr_cfg(8, 0, 0, 6);
    sig[1] = 209; clk_n(1);
    expect_item(1, 1, 1, "R6 code0 enter");
    sig[1] = 208; clk_n(1);
    expect_item(1, 1, 0, "R6 code0 no reduction");

    wr_cfg(8, 1, 0, 6);
    sig[1] = 209; clk_n(1);
    sig[1] = 208; clk_n(1);
    expect_item(1, 1, 1, "R6 code1 threshold 7 held");
    sig[1] = 207; clk_n(1);
    expect_item(1, 1, 0, "R6 code1 leave");

    // confirmation delay 3 with an interruption on key 2
    wr_cfg(4, 0, 0, 3);
    sig[1] = 200;
    sig[2] = 310; clk_n(1);
    expect_item(1, 2, 1, "R5 key2 over");
    tick_n(2);
    sig[2] = 300; clk_n(1);
    sig[2] = 310; clk_n(1);
    tick_n(2);
    expect_item(0, 2, 300, "R8 count cleared no recal");
    tick_once();
    expect_item(2, 0, 1,   "R7 recal on 3rd tick");
    expect_item(0, 2, 310, "R9 ref2 reloaded");
    expect_item(0, 0, 106, "R9 ref0 reloaded");
    expect_item(0, 1, 200, "R9 ref1 reloaded");
    expect_item(0, 3, 400, "R9 ref3 reloaded");
    clk_n(1);
    expect_item(2, 0, 0, "R9 pulse one cycle");

    // drift step and recalibration on the same tick
    wr_cfg(4, 0, 2, 2);
    sig[3] = 402; sig[2] = 320; clk_n(1);
    tick_once(); clk_n(1);
    expect_item(0, 3, 400, "R10 no step after first tick");
    tick_once();
    expect_item(2, 0, 1,   "R10 recal fires");
    expect_item(0, 3, 402, "R10 recal wins over drift");
    expect_item(0, 2, 320, "R10 trigger key reloaded");
    clk_n(1);

    // delay 0 acts as one tick
    wr_cfg(4, 0, 0, 0);
    sig[0] = 120; clk_n(3);
    expect_item(2, 0, 0,   "R7 no recal without tick");
    expect_item(0, 0, 106, "R7 ref0 kept without tick");
    tick_once();
    expect_item(2, 0, 1,   "R7 delay 0 first tick");
    expect_item(0, 0, 120, "R7 ref0 reloaded");
    clk_n(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule